// File: doc/BRIEF.md
# Configurable GPIO Port with Edge-Selectable Interrupts

This block holds the per-pin settings for a small general-purpose I/O port and turns them into pad controls. Software, through a register strobe interface supplied by a separate bus block, chooses for every pin whether it is an input or an output. For outputs it sets the driven level or releases the pin to high impedance. For inputs it sets a pull-up request, a read-side polarity flip, an interrupt enable and the edges that raise an interrupt. Pad levels pass through a synchronizer before any logic uses them.

Edges are judged against a snapshot of the synchronized pin levels. That snapshot is refreshed whenever software reads the input register. A pin has an interrupt pending while its level differs from the snapshot in the selected direction. A read therefore clears the interrupt, and so does a pin that returns to its snapshot level. Any pending pin pulls the active-low interrupt line low; the line is meant to drive an open-drain pad. Polarity inversion changes only the value software reads. Edge detection always looks at the raw pin level.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every pin is an input (direction register reads all ones), `padOe` is all zeros, `irqN` is 1, and the output-level, high-impedance, inversion and interrupt-enable registers read zero, while the rising-select and falling-select registers read all ones.
- R2: `pullEn` resets to all ones when `PULL_UP_AT_RESET` is 1, and to all zeros when it is 0. It then follows writes to the pull-up register (address 4).
- R3: `padOut` equals the output-level register (address 1). `padOe[i]` is 1 exactly when direction bit i is 0 (output) and high-impedance bit i (address 3) is 0.
- R4: Reading address 0 returns the synchronized pin levels XOR the inversion register (address 5). Interrupt edges are judged on the raw, uninverted pin levels.
- R5: When rising-select bit i (address 7) is set, a pin that reads 0 in the snapshot and is now 1 makes interrupt i pending.
- R6: When falling-select bit i (address 8) is set, a pin that reads 1 in the snapshot and is now 0 makes interrupt i pending. With only rising selected, a falling change raises nothing.
- R7: With both select bits set, a change in either direction makes interrupt i pending.
- R8: A read of address 0 (`rdEn` high with `regAddr` 0) loads the snapshot with the current synchronized levels. `irqN` returns to 1 on the clock edge after the read, provided the pins hold steady.
- R9: A pending pin whose level returns to its snapshot value stops pending. `irqN` rises once no other pin is pending.
- R10: Only pins with interrupt-enable (address 6) set and direction set to input (direction bit 1, address 2) can be pending. While a pin is masked or set as an output, its snapshot follows the pin, so later unmasking raises nothing from old history.
- R11: `irqN` falls on the third rising clock edge after a qualifying `padIn` change: two synchronizer stages, then one output register.
- R12: Writes to addresses 1 to 8 load the addressed register on the next clock edge. Writes to address 0 change nothing. Reads of addresses 9 to 15 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 4 | Register address for the read and write strobes |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | WIDTH | Write data |
| rdEn | input | 1 | Read strobe; with address 0 it refreshes the snapshot |
| rdData | output | WIDTH | Combinational read data for `regAddr` |
| padIn | input | WIDTH | Asynchronous pad input levels |
| padOut | output | WIDTH | Pad output values |
| padOe | output | WIDTH | Pad output enables, 1 drives the pad |
| pullEn | output | WIDTH | Pull-up resistor enables |
| irqN | output | 1 | Active-low interrupt, 0 means pull the open-drain line low |

## Verification
The bench builds the port with `PULL_UP_AT_RESET` set to 1, the non-default value, so the reset check sees all-ones pull enables. A later write shows the field is an ordinary register. `WIDTH` stays 8 and `SYNC_STAGES` stays 2, which fixes the three-edge interrupt latency the bench times exactly. Random pin patterns, together with random direction, mask, edge and inversion settings, cover mixed sets of pins against the same snapshot.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam int REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    REG_INPUT = 4'd0,
    REG_OUT   = 4'd1,
    REG_DIR   = 4'd2,
    REG_HIZ   = 4'd3,
    REG_PULL  = 4'd4,
    REG_INV   = 4'd5,
    REG_IEN   = 4'd6,
    REG_RISE  = 4'd7,
    REG_FALL  = 4'd8
  } regSel_e;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrHiz;
    logic wrPull;
    logic wrInv;
    logic wrIen;
    logic wrRise;
    logic wrFall;
    logic rdInput;
    logic warm;
  } regStrobe_t;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= asyncIn;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrEn,
  input  logic                  rdEn,
  output regStrobe_t            strb
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] WARM_END = CNT_W'(SYNC_STAGES);

  logic [CNT_W-1:0] warmCnt;

  // Hold the snapshot on the pins until the synchronizer has filled.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   warmCnt <= '0;
    else if (warmCnt != WARM_END) warmCnt <= warmCnt + 1'b1;
  end

  always_comb begin
    strb         = '0;
    strb.warm    = (warmCnt != WARM_END);
    strb.rdInput = rdEn && (regAddr == REG_INPUT);
    if (wrEn) begin
      case (regAddr)
        REG_OUT:  strb.wrOut  = 1'b1;
        REG_DIR:  strb.wrDir  = 1'b1;
        REG_HIZ:  strb.wrHiz  = 1'b1;
        REG_PULL: strb.wrPull = 1'b1;
        REG_INV:  strb.wrInv  = 1'b1;
        REG_IEN:  strb.wrIen  = 1'b1;
        REG_RISE: strb.wrRise = 1'b1;
        REG_FALL: strb.wrFall = 1'b1;
        default:  ;
      endcase
    end
  end

  // R12: a write strobe reaches at most one register
  assert_single_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrOut, strb.wrDir, strb.wrHiz, strb.wrPull,
              strb.wrInv, strb.wrIen, strb.wrRise, strb.wrFall}));

endmodule

// File: rtl/gpio_edge_dp.sv
module gpio_edge_dp
  import gpio_edge_pkg::*;
#(
  parameter int   WIDTH            = 8,
  parameter bit   PULL_UP_AT_RESET = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strb,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]      wrData,
  input  logic [WIDTH-1:0]      pinNow,
  output logic [WIDTH-1:0]      rdData,
  output logic [WIDTH-1:0]      padOut,
  output logic [WIDTH-1:0]      padOe,
  output logic [WIDTH-1:0]      pullEn,
  output logic                  irqN
);

  logic [WIDTH-1:0] outLevel, dirIn, hiZ, pullReg, invert, irqEnReg, riseSel, fallSel;
  logic [WIDTH-1:0] snap, trackMask, armed, pending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLevel <= '0;
      dirIn    <= '1;
      hiZ      <= '0;
      pullReg  <= {WIDTH{PULL_UP_AT_RESET}};
      invert   <= '0;
      irqEnReg <= '0;
      riseSel  <= '1;
      fallSel  <= '1;
    end else begin
      if (strb.wrOut)  outLevel <= wrData;
      if (strb.wrDir)  dirIn    <= wrData;
      if (strb.wrHiz)  hiZ      <= wrData;
      if (strb.wrPull) pullReg  <= wrData;
      if (strb.wrInv)  invert   <= wrData;
      if (strb.wrIen)  irqEnReg <= wrData;
      if (strb.wrRise) riseSel  <= wrData;
      if (strb.wrFall) fallSel  <= wrData;
    end
  end

  assign padOut = outLevel;
  assign padOe  = ~dirIn & ~hiZ;
  assign pullEn = pullReg;

  // Per-pin edge qualification against the snapshot.
  assign armed = dirIn & irqEnReg;
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign trackMask[i] = strb.warm | strb.rdInput | ~armed[i];
      assign pending[i]   = armed[i] & (pinNow[i] ^ snap[i]) &
                            (pinNow[i] ? riseSel[i] : fallSel[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snap <= '0;
      irqN <= 1'b1;
    end else begin
      snap <= (pinNow & trackMask) | (snap & ~trackMask);
      irqN <= ~|pending;
    end
  end

  always_comb begin
    case (regAddr)
      REG_INPUT: rdData = pinNow ^ invert;
      REG_OUT:   rdData = outLevel;
      REG_DIR:   rdData = dirIn;
      REG_HIZ:   rdData = hiZ;
      REG_PULL:  rdData = pullReg;
      REG_INV:   rdData = invert;
      REG_IEN:   rdData = irqEnReg;
      REG_RISE:  rdData = riseSel;
      REG_FALL:  rdData = fallSel;
      default:   rdData = '0;
    endcase
  end

  // R12: a direction write lands on the next edge
  assert_dir_write_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> (dirIn == $past(wrData)));

  // R8: an input read reloads the snapshot with the sampled pins
  assert_read_reloads_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdInput |=> (snap == $past(pinNow)));

  // R10: all interrupts masked keeps the line released
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnReg == '0) |=> irqN);

  // R10: all pins as outputs keeps the line released
  assert_outputs_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    (dirIn == '0) |=> irqN);

endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH            = 8,
  parameter int SYNC_STAGES      = 2,
  parameter bit PULL_UP_AT_RESET = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  wrEn,
  input  logic [WIDTH-1:0]      wrData,
  input  logic                  rdEn,
  output logic [WIDTH-1:0]      rdData,
  input  logic [WIDTH-1:0]      padIn,
  output logic [WIDTH-1:0]      padOut,
  output logic [WIDTH-1:0]      padOe,
  output logic [WIDTH-1:0]      pullEn,
  output logic                  irqN
);

  regStrobe_t       strb;
  logic [WIDTH-1:0] pinNow;

  gpio_edge_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(padIn), .syncOut(pinNow)
  );

  gpio_edge_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  gpio_edge_dp #(.WIDTH(WIDTH), .PULL_UP_AT_RESET(PULL_UP_AT_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr), .wrData(wrData),
    .pinNow(pinNow), .rdData(rdData), .padOut(padOut), .padOe(padOe),
    .pullEn(pullEn), .irqN(irqN)
  );

endmodule

// File: tb/gpio_edge_port_test.sv
module gpio_edge_port_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] regAddr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData, padOut, padOe, pullEn;
  logic [7:0] padIn = '0;
  logic       irqN;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_edge_port #(.WIDTH(8), .SYNC_STAGES(2), .PULL_UP_AT_RESET(1'b1)) uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .pullEn(pullEn), .irqN(irqN)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [3:0] a, input logic [7:0] d);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [3:0] a, output logic [7:0] d);
    regAddr = a; rdEn = 1'b1;
    #1;
    d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  function automatic logic expIrq(input logic [7:0] base, now, ien, dir, rise, fall);
    logic [7:0] pend;
    pend = (base ^ now) & ((now & rise) | (~now & fall)) & ien & dir;
    return ~|pend;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, base, now, dir, ien, rise, fall, inv, hiz;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 padOe", padOe, 8'h00);
    chk("R1 irqN", {7'd0, irqN}, 8'h01);
    readReg(4'd2, d); chk("R1 dir", d, 8'hFF);
    readReg(4'd1, d); chk("R1 out", d, 8'h00);
    readReg(4'd3, d); chk("R1 hiz", d, 8'h00);
    readReg(4'd5, d); chk("R1 inv", d, 8'h00);
    readReg(4'd6, d); chk("R1 ien", d, 8'h00);
    readReg(4'd7, d); chk("R1 rise", d, 8'hFF);
    readReg(4'd8, d); chk("R1 fall", d, 8'hFF);
    // R2 reset value from parameter, then writable
    chk("R2 pullEn reset", pullEn, 8'hFF);
    writeReg(4'd4, 8'h3C);
    chk("R2 pullEn write", pullEn, 8'h3C);
    readReg(4'd4, d); chk("R2 pull read", d, 8'h3C);

    // R3 pad controls
    writeReg(4'd2, 8'h0F);
    writeReg(4'd3, 8'h30);
    writeReg(4'd1, 8'hA5);
    chk("R3 padOe", padOe, 8'hC0);
    chk("R3 padOut", padOut, 8'hA5);

    // R12 address 0 write ignored, high addresses read zero
    writeReg(4'd0, 8'hFF);
    readReg(4'd2, d); chk("R12 dir kept", d, 8'h0F);
    readReg(4'd0, d); chk("R12 input unchanged", d, 8'h00);
    readReg(4'd9, d); chk("R12 addr9 zero", d, 8'h00);
    readReg(4'd15, d); chk("R12 addr15 zero", d, 8'h00);
    writeReg(4'd3, 8'h00);

    // R5 rising only on pin0, with R11 latency
    writeReg(4'd2, 8'hFF);
    writeReg(4'd7, 8'h01);
    writeReg(4'd8, 8'h00);
    writeReg(4'd6, 8'h01);
    readReg(4'd0, d);
    @(negedge clk); @(negedge clk);
    chk("R8 idle before edge", {7'd0, irqN}, 8'h01);
    padIn = 8'h01;
    @(negedge clk); @(negedge clk);
    chk("R11 not yet", {7'd0, irqN}, 8'h01);
    @(negedge clk);
    chk("R11 R5 rising fires", {7'd0, irqN}, 8'h00);
    readReg(4'd0, d); chk("R4 read value", d, 8'h01);
    @(negedge clk);
    chk("R8 read clears", {7'd0, irqN}, 8'h01);
    padIn = 8'h00; settle();
    chk("R6 falling ignored when rise only", {7'd0, irqN}, 8'h01);

    // R6 falling only on pin1, R9 return clears
    writeReg(4'd7, 8'h00);
    writeReg(4'd8, 8'h02);
    writeReg(4'd6, 8'h02);
    padIn = 8'h02; settle();
    readReg(4'd0, d); @(negedge clk);
    chk("R8 clean start", {7'd0, irqN}, 8'h01);
    padIn = 8'h00; settle();
    chk("R6 falling fires", {7'd0, irqN}, 8'h00);
    padIn = 8'h02; settle();
    chk("R9 return clears", {7'd0, irqN}, 8'h01);

    // R7 both edges on pin2
    writeReg(4'd7, 8'h04);
    writeReg(4'd8, 8'h04);
    writeReg(4'd6, 8'h04);
    readReg(4'd0, d); @(negedge clk);
    padIn = 8'h06; settle();
    chk("R7 rise fires", {7'd0, irqN}, 8'h00);
    readReg(4'd0, d); @(negedge clk);
    chk("R7 cleared", {7'd0, irqN}, 8'h01);
    padIn = 8'h02; settle();
    chk("R7 fall fires", {7'd0, irqN}, 8'h00);
    readReg(4'd0, d); @(negedge clk);

    // R10 output pins and masked pins stay silent
    writeReg(4'd7, 8'hFF);
    writeReg(4'd8, 8'hFF);
    writeReg(4'd2, 8'hFE);
    writeReg(4'd6, 8'h01);
    padIn = 8'h03; settle();
    chk("R10 output pin rise", {7'd0, irqN}, 8'h01);
    padIn = 8'h02; settle();
    chk("R10 output pin fall", {7'd0, irqN}, 8'h01);
    writeReg(4'd2, 8'hFF);
    writeReg(4'd6, 8'h00);
    padIn = 8'h0A; settle();
    chk("R10 masked pin", {7'd0, irqN}, 8'h01);
    writeReg(4'd6, 8'h08);
    settle();
    chk("R10 unmask no stale", {7'd0, irqN}, 8'h01);
    padIn = 8'h02; settle();
    chk("R10 unmasked fires", {7'd0, irqN}, 8'h00);
    readReg(4'd0, d); @(negedge clk);

    // R4 inversion affects reads only
    writeReg(4'd5, 8'hFF);
    writeReg(4'd7, 8'h01);
    writeReg(4'd8, 8'h00);
    writeReg(4'd6, 8'h01);
    readReg(4'd0, d); chk("R4 inverted read", d, 8'hFD);
    @(negedge clk);
    padIn = 8'h03; settle();
    chk("R4 raw rising fires", {7'd0, irqN}, 8'h00);
    readReg(4'd0, d); chk("R4 inverted read 2", d, 8'hFC);
    @(negedge clk);
    chk("R8 clear after inverted read", {7'd0, irqN}, 8'h01);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      base = 8'($urandom); dir = 8'($urandom); ien = 8'($urandom);
      rise = 8'($urandom); fall = 8'($urandom); inv = 8'($urandom);
      hiz = 8'($urandom);
      padIn = base; settle();
      writeReg(4'd2, dir); writeReg(4'd6, ien);
      writeReg(4'd7, rise); writeReg(4'd8, fall);
      writeReg(4'd5, inv); writeReg(4'd3, hiz);
      chk("R3 random padOe", padOe, ~dir & ~hiz);
      readReg(4'd0, d); chk("R4 random read", d, base ^ inv);
      @(negedge clk);
      chk("R8 random clear", {7'd0, irqN}, 8'h01);
      now = 8'($urandom);
      padIn = now; settle();
      chk("R7 random irq", {7'd0, irqN}, {7'd0, expIrq(base, now, ien, dir, rise, fall)});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule